// File: doc/BRIEF.md
# Eight-bit ALU with condition flags

This block is the purely combinational arithmetic and logic unit of a small processor that has two accumulators. The datapath presents two 8-bit operands, the current carry and half-carry flags, and a 4-bit operation code. In the same cycle the block returns an 8-bit result and a write-enable hint. It also returns the next values of the half-carry, negative, zero, overflow and carry flags. The surrounding core owns the registers, the decode and the memory traffic. It stores the result only when the hint is high, and it loads the five flags into its condition register.

All arithmetic is two's complement. Subtraction-type operations report a borrow on the carry flag. Compare and bit test update the flags, but the hint tells the core to leave the destination untouched. Operand A is the destination operand for the single-operand operations: negate, increment, decrement, one's complement, the rotates and pass.

Top module: `alu8_core`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, CMP=3, NEG=4, INC=5, DEC=6, CLR=7, AND=8, OR=9, XOR=10, COM=11, BIT=12, ROL=13, ROR=14, PASS=15. `wr_en` is 0 for CMP and BIT and 1 for every other code.
- R2: ADD gives A+B and ADC gives A+B+carry_in, both modulo 256. The carry flag is the carry out of bit 7, and the half-carry flag is the carry out of bit 3 into bit 4.
- R3: For ADD, ADC, SUB and CMP, the overflow flag is 1 exactly when the signed result falls outside -128..127.
- R4: For every operation, the negative flag equals bit 7 of `result`, and the zero flag is 1 exactly when `result` is 0.
- R5: SUB and CMP give A-B modulo 256 on `result`, with carry set when A < B unsigned (a borrow). CMP reports this difference with `wr_en` low.
- R6: NEG gives 0-A. Carry is 1 unless A is 0, and overflow is 1 only for A = 0x80.
- R7: INC and DEC give A+1 and A-1 modulo 256, and carry keeps `carry_in`. Overflow is 1 for INC of 0x7F and for DEC of 0x80 only.
- R8: CLR gives 0 with overflow 0 and carry 0. COM gives the bitwise inverse of A with overflow 0 and carry 1.
- R9: AND, OR and XOR give the bitwise function of A and B. BIT gives A AND B. All four clear overflow and keep carry at `carry_in`.
- R10: ROL gives {A[6:0], carry_in} with carry = A[7]. ROR gives {carry_in, A[7:1]} with carry = A[0]. For both, overflow = negative XOR new carry.
- R11: For every operation other than ADD and ADC, the half-carry flag equals `half_in`.
- R12: PASS gives A unchanged, with overflow 0 and carry kept at `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see R1) |
| opnd_a | input | 8 | First / destination operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Current carry flag |
| half_in | input | 1 | Current half-carry flag |
| result | output | 8 | Operation result |
| wr_en | output | 1 | Destination should be written |
| flag_h | output | 1 | Next half-carry flag |
| flag_n | output | 1 | Next negative flag |
| flag_z | output | 1 | Next zero flag |
| flag_v | output | 1 | Next overflow flag |
| flag_c | output | 1 | Next carry flag |

## Verification
No register lies between any input and any output, so the result, the hint and all five flags are due in the same cycle that the stimulus is applied, with zero cycles of latency. The bench changes the inputs 1 ns after a rising edge and samples every output 3 ns later, well before the next edge. It compares the outputs against a model written with integer arithmetic. Directed vectors cover the wrap and sign boundaries (0x7F, 0x80, 0xFF, 0x00, and the nibble carry). These run alongside seeded random vectors across all sixteen codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned DW = 8;
  localparam int unsigned NW = DW / 2;
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_CMP  = 4'd3,
    OP_NEG  = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_CLR  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_COM  = 4'd11,
    OP_BIT  = 4'd12,
    OP_ROL  = 4'd13,
    OP_ROR  = 4'd14,
    OP_PASS = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          v;
    logic          h;
  } part_t;

  // Full add with incoming carry; carry out of the top and of the low nibble.
  function automatic part_t f_add(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                  input logic ci);
    part_t         p;
    logic [DW:0]   s;
    logic [NW:0]   lo;
    s  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
    lo = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, ci};
    p.res = s[DW-1:0];
    p.c   = s[DW];
    p.h   = lo[NW];
    p.v   = (a[DW-1] == b[DW-1]) && (s[DW-1] != a[DW-1]);
    return p;
  endfunction

  // Subtract a-b; carry reports a borrow.
  function automatic part_t f_sub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    part_t       p;
    logic [DW:0] d;
    d = {1'b0, a} - {1'b0, b};
    p.res = d[DW-1:0];
    p.c   = d[DW];
    p.h   = 1'b0;
    p.v   = (a[DW-1] ^ b[DW-1]) & (a[DW-1] ^ d[DW-1]);
    return p;
  endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output part_t         part,
  output logic          arith_sel,
  output logic          half_gen
);

  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] ZERO = '0;

  part_t tmp;

  always_comb begin
    tmp  = '0;
    part = '0;
    unique case (op)
      OP_ADD: part = f_add(a, b, 1'b0);
      OP_ADC: part = f_add(a, b, cin);
      OP_SUB,
      OP_CMP: part = f_sub(a, b);
      OP_NEG: part = f_sub(ZERO, a);
      OP_INC: begin
        tmp  = f_add(a, ONE, 1'b0);
        part = '{res: tmp.res, c: cin, v: tmp.v, h: 1'b0};
      end
      OP_DEC: begin
        tmp  = f_sub(a, ONE);
        part = '{res: tmp.res, c: cin, v: tmp.v, h: 1'b0};
      end
      default: part = '0;
    endcase
  end

  assign arith_sel = (op inside {OP_ADD, OP_ADC, OP_SUB, OP_CMP, OP_NEG, OP_INC, OP_DEC});
  assign half_gen  = (op inside {OP_ADD, OP_ADC});

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output part_t         part
);

  logic [DW-1:0] rol_v;
  logic [DW-1:0] ror_v;

  assign rol_v = {a[DW-2:0], cin};
  assign ror_v = {cin, a[DW-1:1]};

  always_comb begin
    part = '{res: '0, c: cin, v: 1'b0, h: 1'b0};
    unique case (op)
      OP_CLR:  part = '{res: '0, c: 1'b0, v: 1'b0, h: 1'b0};
      OP_AND,
      OP_BIT:  part.res = a & b;
      OP_OR:   part.res = a | b;
      OP_XOR:  part.res = a ^ b;
      OP_COM:  part = '{res: ~a, c: 1'b1, v: 1'b0, h: 1'b0};
      OP_ROL:  part = '{res: rol_v, c: a[DW-1], v: rol_v[DW-1] ^ a[DW-1], h: 1'b0};
      OP_ROR:  part = '{res: ror_v, c: a[0], v: ror_v[DW-1] ^ a[0], h: 1'b0};
      OP_PASS: part.res = a;
      default: part = '{res: '0, c: cin, v: 1'b0, h: 1'b0};
    endcase
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  alu_op_e       op,
  input  part_t         arith_part,
  input  part_t         logic_part,
  input  logic          arith_sel,
  input  logic          half_gen,
  input  logic          half_in,
  output logic [DW-1:0] res,
  output logic          wr,
  output logic          h,
  output logic          n,
  output logic          z,
  output logic          v,
  output logic          c
);

  part_t sel;

  assign sel = arith_sel ? arith_part : logic_part;
  assign res = sel.res;
  assign n   = sel.res[DW-1];
  assign z   = ~|sel.res;
  assign v   = sel.v;
  assign c   = sel.c;
  assign h   = half_gen ? arith_part.h : half_in;
  assign wr  = !(op inside {OP_CMP, OP_BIT});

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [3:0] op_sel,
  input  logic [7:0] opnd_a,
  input  logic [7:0] opnd_b,
  input  logic       carry_in,
  input  logic       half_in,
  output logic [7:0] result,
  output logic       wr_en,
  output logic       flag_h,
  output logic       flag_n,
  output logic       flag_z,
  output logic       flag_v,
  output logic       flag_c
);

  alu_op_e op;
  part_t   arith_part;
  part_t   logic_part;
  logic    arith_sel;
  logic    half_gen;

  assign op = alu_op_e'(op_sel);

  alu8_arith u_arith (
    .op       (op),
    .a        (opnd_a),
    .b        (opnd_b),
    .cin      (carry_in),
    .part     (arith_part),
    .arith_sel(arith_sel),
    .half_gen (half_gen)
  );

  alu8_logic u_logic (
    .op  (op),
    .a   (opnd_a),
    .b   (opnd_b),
    .cin (carry_in),
    .part(logic_part)
  );

  alu8_flags u_flags (
    .op        (op),
    .arith_part(arith_part),
    .logic_part(logic_part),
    .arith_sel (arith_sel),
    .half_gen  (half_gen),
    .half_in   (half_in),
    .res       (result),
    .wr        (wr_en),
    .h         (flag_h),
    .n         (flag_n),
    .z         (flag_z),
    .v         (flag_v),
    .c         (flag_c)
  );

endmodule

// File: rtl/alu8_checker.sv
module alu8_checker (
  input logic [3:0] op_sel,
  input logic [7:0] opnd_a,
  input logic [7:0] opnd_b,
  input logic       carry_in,
  input logic       half_in,
  input logic [7:0] result,
  input logic       wr_en,
  input logic       flag_h,
  input logic       flag_n,
  input logic       flag_z,
  input logic       flag_v,
  input logic       flag_c
);

  always_comb begin
    if (op_sel == 4'd3 || op_sel == 4'd12) begin
      p_no_write_r1: assert (!wr_en) else $error("CMP/BIT asked for a write");
    end
    p_sign_zero_r4: assert (flag_n == result[7] && flag_z == (result == 8'h00))
      else $error("N/Z disagree with result");
    if (op_sel == 4'd7) begin
      p_clear_r8: assert (result == 8'h00 && !flag_c && !flag_v) else $error("CLR wrong");
    end
    if (op_sel == 4'd11) begin
      p_com_carry_r8: assert (flag_c && result == ~opnd_a) else $error("COM wrong");
    end
    if (op_sel == 4'd13) begin
      p_rol_carry_r10: assert (flag_c == opnd_a[7] && result[0] == carry_in)
        else $error("ROL wrong");
    end
    if (op_sel >= 4'd2) begin
      p_half_hold_r11: assert (flag_h == half_in) else $error("H changed");
    end
    if (op_sel == 4'd12) begin
      p_bit_and_r9: assert (result == (opnd_a & opnd_b) && !flag_v) else $error("BIT wrong");
    end
  end

endmodule

bind alu8_core alu8_checker u_alu8_checker (
  .op_sel  (op_sel),
  .opnd_a  (opnd_a),
  .opnd_b  (opnd_b),
  .carry_in(carry_in),
  .half_in (half_in),
  .result  (result),
  .wr_en   (wr_en),
  .flag_h  (flag_h),
  .flag_n  (flag_n),
  .flag_z  (flag_z),
  .flag_v  (flag_v),
  .flag_c  (flag_c)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;

  logic       clk = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] opnd_a = '0;
  logic [7:0] opnd_b = '0;
  logic       carry_in = 1'b0;
  logic       half_in = 1'b0;
  logic [7:0] result;
  logic       wr_en, flag_h, flag_n, flag_z, flag_v, flag_c;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  alu8_core u_alu8_core (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .carry_in(carry_in), .half_in(half_in),
    .result(result), .wr_en(wr_en), .flag_h(flag_h), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  // Expected {result, wr, h, n, z, v, c} from integer arithmetic.
  function automatic logic [13:0] model(input int op, input int a, input int b,
                                        input int ci, input int hi);
    int r, sa, sb, sr, wr, h, v, c;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    wr = (op == 3 || op == 12) ? 0 : 1;
    h = hi; v = 0; c = ci; r = 0;
    case (op)
      0, 1: begin
        int k;
        k = (op == 1) ? ci : 0;
        r = a + b + k; c = (r > 255) ? 1 : 0;
        h = ((a % 16) + (b % 16) + k > 15) ? 1 : 0;
        sr = sa + sb + k; v = (sr > 127 || sr < -128) ? 1 : 0;
      end
      2, 3: begin
        r = a - b; c = (r < 0) ? 1 : 0;
        sr = sa - sb; v = (sr > 127 || sr < -128) ? 1 : 0;
      end
      4: begin r = -a; c = (a != 0) ? 1 : 0; v = (a == 128) ? 1 : 0; end
      5: begin r = a + 1; v = (a == 127) ? 1 : 0; end
      6: begin r = a - 1; v = (a == 128) ? 1 : 0; end
      7: begin r = 0; c = 0; end
      8, 12: r = a & b;
      9: r = a | b;
      10: r = a ^ b;
      11: begin r = 255 - a; c = 1; end
      13: begin r = (a * 2) % 256 + ci; c = a / 128; v = ((r / 128) != c) ? 1 : 0; end
      14: begin r = a / 2 + ci * 128; c = a % 2; v = ((r / 128) != c) ? 1 : 0; end
      default: r = a;
    endcase
    r = ((r % 256) + 256) % 256;
    return {r[7:0], wr[0], h[0], r[7], (r == 0), v[0], c[0]};
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R5";
      4: return "R6";
      5, 6: return "R7";
      7, 11: return "R8";
      8, 9, 10, 12: return "R9";
      13, 14: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [13:0] exp);
    logic [13:0] act;
    act = {result, wr_en, flag_h, flag_n, flag_z, flag_v, flag_c};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h ci=%0b hi=%0b actual=%h expected=%h",
               tag, op_sel, opnd_a, opnd_b, carry_in, half_in, act, exp);
    end
  endtask

  // Results are combinational: drive 1 ns after an edge, sample 3 ns later.
  task automatic run(input string tag, input int op, input int a, input int b,
                     input int ci, input int hi);
    @(posedge clk);
    #1;
    op_sel = op[3:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
    carry_in = ci[0]; half_in = hi[0];
    #3;
    check(tag, model(op, a, b, ci, hi));
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0a1b);
    // idle inputs: ADD of zeros gives zero with Z set (R4)
    run("R4", 0, 0, 0, 0, 0);
    run("R2", 0, 8'h0f, 8'h01, 0, 0);          // half carry
    run("R2", 1, 8'hff, 8'h00, 1, 0);          // ADC wrap, carry
    run("R3", 0, 8'h7f, 8'h01, 0, 0);          // signed overflow
    run("R3", 2, 8'h80, 8'h01, 0, 0);          // sub overflow
    run("R5", 2, 8'h10, 8'h20, 0, 1);          // borrow
    run("R1", 3, 8'h42, 8'h42, 0, 0);          // compare equal, no write
    run("R6", 4, 8'h80, 0, 0, 0);
    run("R6", 4, 8'h00, 0, 1, 0);
    run("R7", 5, 8'h7f, 0, 1, 0);
    run("R7", 6, 8'h80, 0, 0, 1);
    run("R7", 5, 8'hff, 0, 0, 0);
    run("R8", 7, 8'h55, 8'h33, 1, 1);
    run("R8", 11, 8'h00, 0, 0, 0);
    run("R9", 12, 8'hf0, 8'h0f, 1, 0);
    run("R1", 12, 8'hff, 8'h81, 0, 0);
    run("R10", 13, 8'h80, 0, 0, 0);
    run("R10", 14, 8'h01, 0, 1, 0);
    run("R11", 9, 8'h01, 8'h02, 0, 1);
    run("R12", 15, 8'h9a, 8'h00, 1, 0);
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(15, 0));
      run(tag_of(op), op, int'($urandom_range(255, 0)), int'($urandom_range(255, 0)),
          int'($urandom_range(1, 0)), int'($urandom_range(1, 0)));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule